// File: doc/BRIEF.md
# State-Enable Gated Environment-Configuration CSR Unit

This block holds word 0 of the machine, hypervisor and supervisor state-enable registers, together with the supervisor and hypervisor environment-configuration registers. It answers one CSR access per cycle. Each answer decides whether the access may proceed, gives the read value, and gives an exception code when the access is refused.

Access to the three environment-configuration addresses is controlled by one enable bit, bit 62, in each state-enable register. The check moves down the privilege stack: machine first, then hypervisor when virtualized, then supervisor for user-mode code. A refusal at the machine level is an illegal-instruction exception. A refusal at the hypervisor level, or a refusal of virtualized user code at the supervisor level, is a virtual-instruction fault.

The answer is combinational on the request. Register updates take effect at the next rising clock edge. An accepted write is applied through a per-register writable mask.

Top module: `stateen_csr_gate`

## Requirements
- R1: When priv is machine (3), or `has_stateen` is 0, an access to senvcfg (0x10A), henvcfg (0x60A) or henvcfgh (0x61A) passes the state-enable check.
- R2: Otherwise, if bit 62 of mstateen0 is 0, an access to any of these three addresses gets exception code 1 (illegal instruction). This check takes precedence over every other state-enable check.
- R3: With virt=1 and mstateen0 bit 62 set, if hstateen0 bit 62 is 0, an access to these three addresses gets code 2 (virtual instruction).
- R4: With virt=1, priv user (0), and mstateen0 and hstateen0 bit 62 both set, if sstateen0 bit 62 is 0, the access gets code 2.
- R5: With virt=0, priv user and `has_s`=1, if mstateen0 bit 62 is set and sstateen0 bit 62 is 0, the access gets code 1. With `has_s`=0 this check is skipped. Supervisor mode is never gated by sstateen0.
- R6: An accepted write to senvcfg changes only bits 0, 4, 5, 6 and 7. All other bits read back as before.
- R7: An accepted write to henvcfg changes bits 0, 4, 5, 6 and 7. When `xlen64`=1 it also changes bits 62 and 63.
- R8: An accepted write to henvcfgh moves `wdata[31:30]` into henvcfg bits 63:62 and changes nothing else. A read of henvcfgh returns henvcfg bits 63:32 zero-extended.
- R9: Only bits 63 and 62 of mstateen0 (0x30C), hstateen0 (0x60C) and sstateen0 (0x10C) are writable. The high-half addresses mstateen0h (0x31C) and hstateen0h (0x61C) write `wdata[31:30]` into bits 63:62 and read back bits 63:32.
- R10: After reset all registers are zero. A refused access (`acc_ok`=0) changes no register and drives `rdata` to zero.
- R11: The mstateen0 addresses need machine mode; otherwise code 1. The hstateen0 addresses need machine mode or non-virtualized supervisor mode; otherwise code 2 when virt=1 and code 1 when virt=0. sstateen0 needs supervisor or machine mode; otherwise code 2 for virtualized user mode and code 1 for plain user mode. Unknown addresses and priv=2 get code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A CSR access is presented this cycle |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | CSR address |
| req_wdata | input | 64 | Write data |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Virtualization mode active |
| xlen64 | input | 1 | 64-bit register width in effect |
| has_s | input | 1 | Supervisor mode implemented |
| has_stateen | input | 1 | State-enable gating implemented |
| rdata | output | 64 | Read value, zero unless the access is accepted |
| acc_ok | output | 1 | Access accepted |
| exc_code | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |

## Verification
Several properties are checked on every cycle. Machine mode always passes the gate. A cleared machine enable bit refuses an access with the illegal code before any other check. A refusal leaves every register untouched with zero read data. The bits outside each writable mask never move. The bench checks the layered cases against a reference model over random mixes of privilege, virtualization and extension flags. These cases are hypervisor and supervisor refusals, the user-mode split on `has_s`, the width-dependent henvcfg mask and the high-half packing. Only those scenarios show that accepted writes land in the correct fields and read back correctly.

// File: rtl/stateen_csr_gate.sv
module stateen_csr_gate #(
  parameter int ENV_BIT = 62,
  parameter int SE_BIT  = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [11:0] req_addr,
  input  logic [63:0] req_wdata,
  input  logic [1:0]  priv,
  input  logic        virt,
  input  logic        xlen64,
  input  logic        has_s,
  input  logic        has_stateen,
  output logic [63:0] rdata,
  output logic        acc_ok,
  output logic [1:0]  exc_code
);
  localparam logic [11:0] A_SENV  = 12'h10A;
  localparam logic [11:0] A_SSE   = 12'h10C;
  localparam logic [11:0] A_HENV  = 12'h60A;
  localparam logic [11:0] A_HENVH = 12'h61A;
  localparam logic [11:0] A_HSE   = 12'h60C;
  localparam logic [11:0] A_HSEH  = 12'h61C;
  localparam logic [11:0] A_MSE   = 12'h30C;
  localparam logic [11:0] A_MSEH  = 12'h31C;
  localparam logic [1:0] P_U = 2'd0, P_S = 2'd1, P_M = 2'd3;
  localparam logic [1:0] X_NONE = 2'd0, X_ILL = 2'd1, X_VIRT = 2'd2;
  localparam logic [63:0] SE_MASK  = (64'd1 << SE_BIT) | (64'd1 << ENV_BIT);
  localparam logic [63:0] ENV_LOW  = 64'h0000_0000_0000_00F1;
  localparam logic [63:0] ENV_HIGH = 64'hC000_0000_0000_0000;

  logic [63:0] mse, hse, sse, senv, henv;
  logic [1:0]  gate_exc, exc;
  logic [63:0] rd_val, wr_hi, henv_mask;
  logic        is_env;

  assign is_env    = (req_addr == A_SENV) || (req_addr == A_HENV) || (req_addr == A_HENVH);
  assign wr_hi     = {req_wdata[31:0], 32'b0};
  assign henv_mask = xlen64 ? (ENV_LOW | ENV_HIGH) : ENV_LOW;

  always_comb begin
    gate_exc = X_NONE;
    if (priv != P_M && has_stateen) begin
      if (!mse[ENV_BIT])                                  gate_exc = X_ILL;
      else if (virt && !hse[ENV_BIT])                     gate_exc = X_VIRT;
      else if (virt && priv == P_U && !sse[ENV_BIT])      gate_exc = X_VIRT;
      else if (!virt && priv == P_U && has_s && !sse[ENV_BIT]) gate_exc = X_ILL;
    end
  end

  always_comb begin
    exc    = X_ILL;
    rd_val = '0;
    if (priv != 2'd2) begin
      if (is_env) exc = gate_exc;
      else begin
        case (req_addr)
          A_MSE, A_MSEH: exc = (priv == P_M) ? X_NONE : X_ILL;
          A_HSE, A_HSEH: exc = (priv == P_M || (priv == P_S && !virt)) ? X_NONE :
                               (virt ? X_VIRT : X_ILL);
          A_SSE:         exc = (priv != P_U) ? X_NONE : (virt ? X_VIRT : X_ILL);
          default:       exc = X_ILL;
        endcase
      end
    end
    case (req_addr)
      A_SENV:  rd_val = senv;
      A_HENV:  rd_val = henv;
      A_HENVH: rd_val = {32'b0, henv[63:32]};
      A_MSE:   rd_val = mse;
      A_MSEH:  rd_val = {32'b0, mse[63:32]};
      A_HSE:   rd_val = hse;
      A_HSEH:  rd_val = {32'b0, hse[63:32]};
      A_SSE:   rd_val = sse;
      default: rd_val = '0;
    endcase
  end

  assign exc_code = req_valid ? exc : X_NONE;
  assign acc_ok   = req_valid && (exc == X_NONE);
  assign rdata    = acc_ok ? rd_val : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mse <= '0; hse <= '0; sse <= '0; senv <= '0; henv <= '0;
    end else if (acc_ok && req_we) begin
      case (req_addr)
        A_SENV:  senv <= (senv & ~ENV_LOW)   | (req_wdata & ENV_LOW);
        A_HENV:  henv <= (henv & ~henv_mask) | (req_wdata & henv_mask);
        A_HENVH: henv <= (henv & ~ENV_HIGH)  | (wr_hi & ENV_HIGH);
        A_MSE:   mse  <= (mse & ~SE_MASK)    | (req_wdata & SE_MASK);
        A_MSEH:  mse  <= (mse & ~SE_MASK)    | (wr_hi & SE_MASK);
        A_HSE:   hse  <= (hse & ~SE_MASK)    | (req_wdata & SE_MASK);
        A_HSEH:  hse  <= (hse & ~SE_MASK)    | (wr_hi & SE_MASK);
        A_SSE:   sse  <= (sse & ~SE_MASK)    | (req_wdata & SE_MASK);
        default: ;
      endcase
    end
  end

  AST_MACHINE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_env && (priv == P_M || !has_stateen)) |-> acc_ok); // R1
  AST_MACHINE_BIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_env && priv != P_M && has_stateen && !mse[ENV_BIT]) |-> exc_code == X_ILL); // R2
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok) |=> ($stable(mse) && $stable(hse) && $stable(sse) && $stable(senv) && $stable(henv))); // R10
  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |-> rdata == 64'd0); // R10
  AST_SENV_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(senv & ~ENV_LOW)); // R6
  AST_SE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(mse & ~SE_MASK) && $stable(hse & ~SE_MASK) && $stable(sse & ~SE_MASK))); // R9
endmodule

// File: tb/stateen_csr_gate_test.sv
module stateen_csr_gate_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, virt = 0, xlen64 = 1, has_s = 1, has_stateen = 1;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0] priv = 2'd3;
  logic [63:0] rdata;
  logic acc_ok;
  logic [1:0] exc_code;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] m_mse = 0, m_hse = 0, m_sse = 0, m_senv = 0, m_henv = 0;

  stateen_csr_gate uut (.clk, .rst_n, .req_valid, .req_we, .req_addr, .req_wdata, .priv, .virt,
    .xlen64, .has_s, .has_stateen, .rdata, .acc_ok, .exc_code);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit env_addr(logic [11:0] a);
    return a == 12'h10A || a == 12'h60A || a == 12'h61A;
  endfunction

  function automatic logic [1:0] exp_exc(logic [11:0] a, logic [1:0] p, logic v, logic hs, logic hst);
    if (p == 2'd2) return 2'd1;
    if (env_addr(a)) begin
      if (p == 2'd3 || !hst) return 2'd0;
      if (!m_mse[62]) return 2'd1;
      if (v && !m_hse[62]) return 2'd2;
      if (v && p == 2'd0 && !m_sse[62]) return 2'd2;
      if (!v && p == 2'd0 && hs && !m_sse[62]) return 2'd1;
      return 2'd0;
    end
    case (a)
      12'h30C, 12'h31C: return p == 2'd3 ? 2'd0 : 2'd1;
      12'h60C, 12'h61C: return (p == 2'd3 || (p == 2'd1 && !v)) ? 2'd0 : (v ? 2'd2 : 2'd1);
      12'h10C: return p != 2'd0 ? 2'd0 : (v ? 2'd2 : 2'd1);
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [63:0] exp_read(logic [11:0] a);
    case (a)
      12'h10A: return m_senv;
      12'h60A: return m_henv;
      12'h61A: return {32'b0, m_henv[63:32]};
      12'h30C: return m_mse;
      12'h31C: return {32'b0, m_mse[63:32]};
      12'h60C: return m_hse;
      12'h61C: return {32'b0, m_hse[63:32]};
      12'h10C: return m_sse;
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a, logic [1:0] p, logic v, logic we, logic [1:0] e);
    if (p == 2'd3 && env_addr(a) && !we) return "R1";
    if (env_addr(a) && e == 2'd1 && !m_mse[62]) return "R2";
    if (env_addr(a) && e == 2'd2 && !m_hse[62]) return "R3";
    if (env_addr(a) && e == 2'd2) return "R4";
    if (env_addr(a) && p == 2'd0 && !v) return "R5";
    if (a == 12'h10A && we) return "R6";
    if (a == 12'h60A && we) return "R7";
    if (a == 12'h61A) return "R8";
    if (e != 2'd0 && !env_addr(a)) return "R11";
    if (!env_addr(a)) return "R9";
    return "R10";
  endfunction

  task automatic access(logic we, logic [11:0] a, logic [63:0] wd, logic [1:0] p, logic v,
                        logic x64, logic hs, logic hst, string tag = "");
    logic [1:0] e; logic [63:0] r; string t;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd; priv = p; virt = v;
    xlen64 = x64; has_s = hs; has_stateen = hst;
    e = exp_exc(a, p, v, hs, hst);
    r = (e == 2'd0) ? exp_read(a) : 64'd0;
    t = (tag != "") ? tag : tag_of(a, p, v, we, e);
    #(CLK_PERIOD/4);
    checks++;
    if (exc_code !== e || acc_ok !== (e == 2'd0) || rdata !== r) begin
      errors++;
      $display("FAIL %s addr=%h priv=%0d virt=%0d we=%0d: exc=%0d ok=%0d rdata=%h expected exc=%0d ok=%0d rdata=%h",
               t, a, p, v, we, exc_code, acc_ok, rdata, e, e == 2'd0, r);
    end
    if (e == 2'd0 && we) begin
      case (a)
        12'h10A: m_senv = (m_senv & ~64'hF1) | (wd & 64'hF1);
        12'h60A: begin
          logic [63:0] mk; mk = x64 ? 64'hC000_0000_0000_00F1 : 64'hF1;
          m_henv = (m_henv & ~mk) | (wd & mk);
        end
        12'h61A: m_henv = {wd[31:30], m_henv[61:0]};
        12'h30C: m_mse = {wd[63:62], 62'd0};
        12'h31C: m_mse = {wd[31:30], 62'd0};
        12'h60C: m_hse = {wd[63:62], 62'd0};
        12'h61C: m_hse = {wd[31:30], 62'd0};
        12'h10C: m_sse = {wd[63:62], 62'd0};
        default: ;
      endcase
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  localparam logic [11:0] ADDRS [9] = '{12'h10A, 12'h60A, 12'h61A, 12'h30C, 12'h31C,
                                        12'h60C, 12'h61C, 12'h10C, 12'h7C3};

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10: reset values read as zero from machine mode
    foreach (ADDRS[i]) access(0, ADDRS[i], 0, 2'd3, 0, 1, 1, 1, "R10");
    // R2: machine bit clear wins even in virtualized user mode
    access(0, 12'h10A, 0, 2'd0, 1, 1, 1, 1, "R2");
    // R1: no state-enable extension means no gating
    access(1, 12'h10A, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 0, 1, 1, 0, "R1");
    // R6: only fields 0,4..7 of senvcfg stick
    access(0, 12'h10A, 0, 2'd3, 0, 1, 1, 1, "R6");
    // R9: open machine bit, hypervisor remains closed
    access(1, 12'h30C, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 1, 1, 1, "R9");
    access(0, 12'h30C, 0, 2'd3, 0, 1, 1, 1, "R9");
    // R3: hypervisor bit clear in VS mode
    access(0, 12'h60A, 0, 2'd1, 1, 1, 1, 1, "R3");
    // R5: plain user mode split on has_s
    access(0, 12'h60A, 0, 2'd0, 0, 1, 1, 1, "R5");
    access(0, 12'h60A, 0, 2'd0, 0, 1, 0, 1, "R5");
    // R9: high-half write of hstateen0
    access(1, 12'h61C, 64'h4000_0000, 2'd1, 0, 1, 1, 1, "R9");
    access(0, 12'h60C, 0, 2'd3, 0, 1, 1, 1, "R9");
    // R4: VU with supervisor bit clear
    access(0, 12'h10A, 0, 2'd0, 1, 1, 1, 1, "R4");
    // R7: 32-bit mode leaves high fields of henvcfg
    access(1, 12'h60A, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 0, 1, 1, "R7");
    access(0, 12'h60A, 0, 2'd3, 0, 1, 1, 1, "R7");
    // R8: high half write and read
    access(1, 12'h61A, 64'h8000_0000, 2'd3, 0, 0, 1, 1, "R8");
    access(0, 12'h61A, 0, 2'd3, 0, 1, 1, 1, "R8");
    // R11: privilege code 2 and an unknown address
    access(0, 12'h30C, 0, 2'd2, 0, 1, 1, 1, "R11");
    access(1, 12'h7C3, 64'h1, 2'd3, 0, 1, 1, 1, "R11");
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] p; logic v; int k;
      k = $urandom_range(0, 9);
      p = (k < 3) ? 2'd3 : (k < 6 ? 2'd1 : 2'd0);
      v = (p == 2'd3) ? 1'b0 : 1'($urandom_range(0, 1));
      access(1'($urandom_range(0, 1)), ADDRS[$urandom_range(0, 8)], {$urandom, $urandom}, p, v,
             1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), ($urandom_range(0, 5) != 0));
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule